// File: doc/BRIEF.md
# ADC Control Word Receiver

This block is the serial front end of a four-channel sampling converter. It is the device side of the link. A host selects it with an active-low chip select and clocks 16-bit frames into it, most significant bit first. The top twelve bits of each frame form a control word. When the write flag in that word is set, the block latches the word into a control register: analog channel, power mode, sequence mode, input span and output coding. The lowest four bits of every frame are ignored.

In the same frame the block shifts a result word back to the host. This word holds a 4-bit channel identifier and a 12-bit data field. The conversion itself is not modelled. Each channel has a parallel sample input, and the block returns the value present on that input when the frame begins. The returned channel is the one held in the register when chip select falls, so a frame reports the channel that the previous frame selected.

All serial inputs are resynchronised to a fast system clock, and SCLK edges are detected in that clock domain. The converter resolution is a parameter (8, 10 or 12 bits). Narrower samples are placed at the top of the 12-bit data field.

Top module: `adcw_ctrl_rx`

## Requirements
- R1: After reset the register holds channel 0, power mode 3 (normal), sequence mode 0, span bit 0 and coding bit 0. MISO is low.
- R2: A frame is 16 bits. MOSI is taken on rising SCLK edges and MISO advances on falling edges, both most significant bit first. The control word is frame bits [15:4].
- R3: The register changes only at the end of a complete frame whose frame bit 15 (control bit 11, the write flag) is 1. A frame with that bit at 0 leaves every field unchanged.
- R4: Channel comes from control bits [7:6] and power mode from control bits [5:4]. The span flag (1 = span equals the reference) comes from control bit 1, and the straight-binary coding flag from control bit 0.
- R5: Sequence mode is formed as {control bit 10, control bit 3}.
- R6: The result word carries the channel identifier (zero-extended channel number) in bits [15:12] and the sample data in bits [11:0].
- R7: The result word is built from the channel held in the register when chip select falls. The first frame after reset therefore returns channel 0.
- R8: With RES_BITS below 12, the sample occupies the upper RES_BITS of the data field and the lower bits read 0.
- R9: If chip select rises before the 16th rising edge, the frame is dropped and the register does not change. The next frame starts counting from its first bit.
- R10: Rising edges after the 16th in the same selection are ignored. They neither update the register nor alter it.
- R11: A 16th rising edge that arrives in the same system cycle as the chip-select rise still completes the frame.
- R12: MISO is driven low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| sample_bus | input | 4*RES_BITS | Per-channel samples, channel 0 in the low bits |
| spi_miso | output | 1 | Serial result data to host |
| chan_sel | output | 2 | Selected analog channel |
| pwr_mode | output | 2 | Power mode field |
| seq_mode | output | 2 | Sequence mode field |
| span_ref | output | 1 | 1 = input span equals the reference, 0 = twice the reference |
| straight_bin | output | 1 | 1 = straight binary output coding |

## Verification
Two events can land in one system cycle: the 16th rising SCLK edge that completes a frame, and the deselect caused by chip select rising. The bench provokes this by driving SCLK high and chip select high together. Both pass through synchronisers of equal depth, so the two edges reach the detection logic in the same cycle. The outcome is judged at the ports. The control fields must take the values of the just-finished frame, and the following frame must return the newly chosen channel.

// File: rtl/adcw_pkg.sv
package adcw_pkg;
  localparam int FRAME_W = 16;
  localparam int CTRL_W  = 12;
  localparam int DATA_W  = 12;
  localparam int NUM_CH  = 4;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] pwr;
    logic [1:0] seq;
    logic       span_ref;
    logic       straight_bin;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{chan: 2'd0, pwr: 2'd3, seq: 2'd0,
                                 span_ref: 1'b0, straight_bin: 1'b0};

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.chan         = w[7:6];
    c.pwr          = w[5:4];
    c.seq          = {w[10], w[3]};
    c.span_ref     = w[1];
    c.straight_bin = w[0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] left_align(input logic [DATA_W-1:0] raw,
                                                   input int unsigned res);
    return raw << (DATA_W - res);
  endfunction

  function automatic logic [FRAME_W-1:0] build_result(input logic [1:0] ch,
                                                      input logic [DATA_W-1:0] d);
    return {2'b00, ch, d};
  endfunction
endpackage

// File: rtl/adcw_sync.sv
module adcw_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adcw_deframer.sv
module adcw_deframer
  import adcw_pkg::*;
#(
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  output logic              selected,
  output logic              cs_fall,
  output logic              sclk_fall,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              frame_end,
  output logic [CTRL_W-1:0] ctrl_word
);
  logic sclk_q, cs_q, sclk_rise, take;
  logic [CTRL_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  assign selected  = ~cs_q;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_fall   = ~cs_s & cs_q;
  assign take      = sclk_rise & selected & (cnt < CNT_W'(FRAME_W));
  assign frame_end = take & (cnt == CNT_W'(FRAME_W - 1));
  assign bit_cnt   = cnt;
  assign ctrl_word = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sh     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
      if (take && cnt < CNT_W'(CTRL_W)) sh <= {sh[CTRL_W-2:0], mosi_s};
      if (cs_s)      cnt <= '0;
      else if (take) cnt <= cnt + 1'b1;
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));

  // R9
  desel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0));
endmodule

// File: rtl/adcw_serializer.sv
module adcw_serializer
  import adcw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift,
  output logic               out_bit
);
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_word;
    else if (shift) sh <= {sh[FRAME_W-2:0], 1'b0};
  end

  assign out_bit = sh[FRAME_W-1];

  // R2
  tx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (out_bit == $past(sh[FRAME_W-2])));
endmodule

// File: rtl/adcw_ctrl_rx.sv
module adcw_ctrl_rx
  import adcw_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_cs_n,
  input  logic                       spi_mosi,
  input  logic [NUM_CH*RES_BITS-1:0] sample_bus,
  output logic                       spi_miso,
  output logic [1:0]                 chan_sel,
  output logic [1:0]                 pwr_mode,
  output logic [1:0]                 seq_mode,
  output logic                       span_ref,
  output logic                       straight_bin
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic sclk_s, cs_s, mosi_s;
  logic selected, cs_fall, sclk_fall, frame_end, upd, tx_shift, tx_bit;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CTRL_W-1:0] ctrl_word;
  logic [RES_BITS-1:0] smp [NUM_CH];
  logic [FRAME_W-1:0] result;
  ctrl_t ctrl_q;

  adcw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_mosi, spi_cs_n, spi_sclk}),
    .q({mosi_s, cs_s, sclk_s})
  );

  adcw_deframer u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .mosi_s(mosi_s),
    .selected(selected), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .bit_cnt(bit_cnt), .frame_end(frame_end), .ctrl_word(ctrl_word)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_smp
      assign smp[c] = sample_bus[c*RES_BITS +: RES_BITS];
    end
  endgenerate

  assign result = build_result(ctrl_q.chan,
                               left_align(DATA_W'(smp[ctrl_q.chan]), RES_BITS));

  assign tx_shift = sclk_fall & selected & (bit_cnt != '0)
                    & (bit_cnt < CNT_W'(FRAME_W));

  adcw_serializer u_tx (
    .clk(clk), .rst_n(rst_n), .load(cs_fall), .load_word(result),
    .shift(tx_shift), .out_bit(tx_bit)
  );

  assign upd = frame_end & ctrl_word[CTRL_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctrl_q <= CTRL_RST;
    else if (upd) ctrl_q <= decode_ctrl(ctrl_word);
  end

  assign spi_miso     = selected & tx_bit;
  assign chan_sel     = ctrl_q.chan;
  assign pwr_mode     = ctrl_q.pwr;
  assign seq_mode     = ctrl_q.seq;
  assign span_ref     = ctrl_q.span_ref;
  assign straight_bin = ctrl_q.straight_bin;

  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ctrl_q));

  // R5
  seq_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (seq_mode == $past({ctrl_word[10], ctrl_word[3]})));
endmodule

// File: tb/tb_adcw_ctrl_rx.sv
module tb_adcw_ctrl_rx;
  localparam int HALF = 6;

  typedef struct packed {
    logic [15:0] frame;
    logic [1:0]  ch;
    logic [1:0]  pm;
    logic [1:0]  sq;
    logic        sp;
    logic        cb;
    logic [1:0]  rid;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{16'h893A, 2'd2, 2'd1, 2'd0, 1'b1, 1'b1, 2'd0},
    '{16'hCF85, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0, 2'd2},
    '{16'h7FF0, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0, 2'd3},
    '{16'hC62F, 2'd1, 2'd2, 2'd2, 1'b1, 1'b0, 2'd3},
    '{16'h8290, 2'd0, 2'd2, 2'd1, 1'b0, 1'b1, 2'd1},
    '{16'h8B3C, 2'd2, 2'd3, 2'd0, 1'b1, 1'b1, 2'd0}
  };

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, miso8;
  logic [1:0] ch, pm, sq, ch8, pm8, sq8;
  logic sp, cb, sp8, cb8;
  logic [11:0] s12 [4] = '{12'h123, 12'h456, 12'h789, 12'hABC};
  logic [7:0]  s8  [4] = '{8'h12, 8'h34, 8'h56, 8'h78};
  int n_chk = 0, n_ok = 0;
  logic [15:0] got, got8;

  always #10 clk = ~clk;

  adcw_ctrl_rx dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .sample_bus({s12[3], s12[2], s12[1], s12[0]}), .spi_miso(miso),
    .chan_sel(ch), .pwr_mode(pm), .seq_mode(sq), .span_ref(sp), .straight_bin(cb));

  adcw_ctrl_rx #(.RES_BITS(8)) dut_b8 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .sample_bus({s8[3], s8[2], s8[1], s8[0]}), .spi_miso(miso8),
    .chan_sel(ch8), .pwr_mode(pm8), .seq_mode(sq8), .span_ref(sp8), .straight_bin(cb8));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act === exp) n_ok++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic fields(input string req, input logic [1:0] ec, input logic [1:0] ep,
                        input logic [1:0] es, input logic esp, input logic ecb);
    check(req, {24'd0, ch, pm, sq, sp, cb}, {24'd0, ec, ep, es, esp, ecb});
  endtask

  task automatic xfer(input logic [19:0] bits, input int nbits, input bit cs_last);
    got = '0; got8 = '0;
    @(negedge clk) cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[19-i];
      repeat (HALF) @(negedge clk);
      if (i < 16) begin got = {got[14:0], miso}; got8 = {got8[14:0], miso8}; end
      sclk = 1;
      if (cs_last && i == nbits - 1) cs_n = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    fields("R1", 2'd0, 2'd3, 2'd0, 1'b0, 1'b0);
    check("R1 miso", {31'd0, miso}, 32'd0);

    // R2 R3 R4 R5 R6 R7 R8 table walk
    foreach (TBL[k]) begin
      xfer({TBL[k].frame, 4'h0}, 16, 1'b0);
      fields("R2/R3/R4/R5", TBL[k].ch, TBL[k].pm, TBL[k].sq, TBL[k].sp, TBL[k].cb);
      check("R6 R7 result", {16'd0, got}, {16'd0, 2'b00, TBL[k].rid, s12[TBL[k].rid]});
      check("R8 left align", {16'd0, got8}, {16'd0, 2'b00, TBL[k].rid, s8[TBL[k].rid], 4'h0});
      check("R12 idle miso", {31'd0, miso}, 32'd0);
    end

    // R9 short frame dropped
    xfer({16'h8000, 4'h0}, 12, 1'b0);
    fields("R9 short", 2'd2, 2'd3, 2'd0, 1'b1, 1'b1);
    xfer({16'h8C00, 4'h0}, 16, 1'b0);
    fields("R9 next frame", 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
    check("R9 result", {16'd0, got}, {16'd0, 16'h2789});

    // R10 extra clocks ignored
    xfer({16'h8410, 4'hF}, 20, 1'b0);
    fields("R10 extra", 2'd1, 2'd0, 2'd0, 1'b0, 1'b1);
    check("R10 result", {16'd0, got}, {16'd0, 16'h3ABC});

    // R11 last edge with deselect
    xfer({16'h8F00, 4'h0}, 16, 1'b1);
    fields("R11 coincident", 2'd3, 2'd3, 2'd0, 1'b0, 1'b0);
    check("R11 result", {16'd0, got}, {16'd0, 16'h1456});
    xfer({16'h0000, 4'h0}, 16, 1'b0);
    check("R11 follow-up channel", {16'd0, got}, {16'd0, 16'h3ABC});
    check("R12 idle miso", {31'd0, miso}, 32'd0);

    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule